// File: doc/BRIEF.md
# I2C Single-Register Access Master

This block carries out exactly one register transaction on an I2C bus for each request from a host. The host presents four things: a 7-bit device address, an 8-bit register index, a direction bit and, for a write, one data byte. It then pulses a start strobe. The block runs the whole bus sequence by itself. When it finishes, it reports a ready flag, a no-acknowledge flag and the last byte it read back. The same values are also offered as one packed 32-bit status word.

Both bus lines are open-drain. SCL is presented as a level where 1 means released. SDA is controlled only through a pull-low enable, and the line is read back on a separate input. The block never drives a bus line high.

An accepted strobe does not start the bus at once. A fixed launch delay follows first, and during it ready stays high and every result output still shows the previous transaction. The host must therefore wait longer than the launch delay before it polls ready, and it must judge every completed transaction by the no-acknowledge flag. SCL is produced by a quarter-period counter. Each bit slot lasts four quarters, and SCL is high for the middle two.

Top module: `i2c_reg_master`

## Requirements
- R1: While reset is held, and afterwards until a strobe is accepted, `ready_o`=1, `nack_o`=0, `rdata_o`=0, `scl_o`=1 and `sda_oe_o`=0. Whenever `ready_o` is 1, both lines are released.
- R2: A strobe is accepted only when the block is idle. A strobe during the launch delay or during a bus transfer is ignored: it changes neither the bytes sent nor the latched command, and no second transaction follows.
- R3: After the clock edge that accepts a strobe, `ready_o` stays 1 for exactly `LAUNCH_CYC` clock edges, counting that edge, and falls on the next one. During that window the lines stay released and `rdata_o` keeps its old value.
- R4: With `rd_i`=0 (write), the bus carries START, the byte {address,0}, the register index, the data byte, then STOP. Each byte is sent MSB first and followed by one acknowledge slot.
- R5: With `rd_i`=1 (read), the bus carries START, {address,0}, the register index, a repeated START, {address,1}, one byte received from the slave, a master not-acknowledge, then STOP. `rdata_o` takes the received byte and changes only while `ready_o` is 0.
- R6: If any acknowledge slot samples SDA high, `nack_o` rises while `ready_o` is 0. The next slot is STOP, no further byte is sent, `rdata_o` is left unchanged and `ready_o` returns to 1. `nack_o` then holds.
- R7: An accepted strobe clears `nack_o` on the accepting edge.
- R8: SDA and SCL never change in the same clock cycle. SDA changes while SCL is high only for START, repeated START and STOP.
- R9: `status_o` is laid out as follows: [31:26]=0, [25]=`nack_o`, [24]=`ready_o`, [23:16]=`rdata_o`, [15:9]=latched address, [8]=latched direction, [7:0]=latched register index. The latched fields are 0 after reset.
- R10: On the bus, each SCL high phase and each SCL low phase between bit slots lasts 2×`QUARTER_CYC` clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | One-cycle request strobe |
| rd_i | input | 1 | Direction: 1 read, 0 write |
| slave_addr_i | input | 7 | Target device address |
| reg_addr_i | input | 8 | Register index inside the device |
| wdata_i | input | 8 | Byte to write |
| sda_i | input | 1 | Sensed level of the SDA line |
| ready_o | output | 1 | Idle; a new strobe is accepted |
| nack_o | output | 1 | A slave acknowledge was missing |
| rdata_o | output | 8 | Last byte read from a slave |
| status_o | output | 32 | Packed command and status word |
| scl_o | output | 1 | SCL level, 1 = released |
| sda_oe_o | output | 1 | SDA pull-low enable |

## Verification
The assertions assume three things. The SDA input is the wired-AND of the block's own enable and a slave that changes SDA only while SCL is low. The start strobe lasts a single clock. Reset is applied from the first edge. The bench meets all three. Its slave model moves its pull only on a sampled SCL falling edge and releases the line on STOP. Every strobe is produced by one task that holds it for exactly one cycle. The bench also asserts reset before the first clock edge.

// File: rtl/i2c_reg_pkg.sv
`timescale 1ns/1ps
// Package: shared types for the single-register I2C master.
// Assumes a bit slot of four quarters, with SCL high in quarters 1 and 2.
package i2c_reg_pkg;

    typedef enum logic [3:0] {
        XS_IDLE,
        XS_LAUNCH,
        XS_START,
        XS_TXBYTE,
        XS_TXACK,
        XS_RSTART,
        XS_RXBYTE,
        XS_MNACK,
        XS_STOP
    } xfer_state_e;

    typedef enum logic [1:0] {
        BY_ADDR_W,
        BY_REG,
        BY_DATA,
        BY_ADDR_R
    } byte_stage_e;

    typedef struct packed {
        logic [6:0] sa;
        logic       rd;
        logic [7:0] ra;
        logic [7:0] wd;
    } cmd_t;

    typedef struct packed {
        logic scl;       // 1 = released
        logic sda_pull;  // 1 = pull SDA low
    } lines_t;

    // Line levels for a given slot kind, quarter and outgoing bit.
    function automatic lines_t slot_lines(xfer_state_e st, logic [1:0] q, logic txbit);
        lines_t l;
        logic   mid;
        mid = (q == 2'd1) || (q == 2'd2);
        l   = '{scl: 1'b1, sda_pull: 1'b0};
        case (st)
            XS_START: begin
                l.scl      = (q == 2'd0) || (q == 2'd1);
                l.sda_pull = (q != 2'd0);
            end
            XS_TXBYTE: begin
                l.scl      = mid;
                l.sda_pull = !txbit;
            end
            XS_TXACK, XS_RXBYTE, XS_MNACK: begin
                l.scl      = mid;
                l.sda_pull = 1'b0;
            end
            XS_RSTART: begin
                l.scl      = mid;
                l.sda_pull = (q == 2'd2) || (q == 2'd3);
            end
            XS_STOP: begin
                l.scl      = (q != 2'd0);
                l.sda_pull = (q == 2'd0) || (q == 2'd1);
            end
            default: l = '{scl: 1'b1, sda_pull: 1'b0};
        endcase
        return l;
    endfunction

endpackage

// File: rtl/i2c_interval_timer.sv
`timescale 1ns/1ps
// Module: interval timer.
// Emits a one-cycle tick every INTERVAL cycles while run_i is high.
// The count restarts from zero whenever run_i is low. Assumes INTERVAL >= 1.
module i2c_interval_timer #(
    parameter int unsigned INTERVAL = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic tick_o
);
    localparam int unsigned CW = (INTERVAL > 1) ? $clog2(INTERVAL) : 1;
    localparam logic [CW-1:0] LAST = CW'(INTERVAL - 1);

    logic [CW-1:0] cnt_q;

    assign tick_o = run_i && (cnt_q == LAST);

    // Count cycles within the current interval.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_i) begin
            cnt_q <= '0;
        end else if (tick_o) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/i2c_xfer_ctrl.sv
`timescale 1ns/1ps
// Module: transfer sequencer.
// Walks through the slots of one write or read transaction. Samples SDA at
// the end of quarter 2 and registers both line levels.
// Assumes qtick_i pulses once per quarter while bus_run_o is high, and
// launch_done_i pulses once at the end of the launch delay.
module i2c_xfer_ctrl
    import i2c_reg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  cmd_t       cmd_i,
    input  logic       launch_done_i,
    input  logic       qtick_i,
    input  logic       sda_i,
    output logic       launch_run_o,
    output logic       bus_run_o,
    output logic       ready_o,
    output logic       nack_o,
    output logic [7:0] rdata_o,
    output logic [6:0] cmd_sa_o,
    output logic       cmd_rd_o,
    output logic [7:0] cmd_ra_o,
    output logic       scl_o,
    output logic       sda_oe_o
);
    xfer_state_e state_q;
    byte_stage_e stage_q;
    logic [1:0]  phase_q;
    logic [2:0]  bit_q;
    logic [7:0]  shift_q;
    cmd_t        cmd_q;
    logic [7:0]  rdata_q;
    logic        nack_q;
    lines_t      lines_q;
    logic        slot_end;
    logic        sample_now;

    assign ready_o      = (state_q == XS_IDLE) || (state_q == XS_LAUNCH);
    assign launch_run_o = (state_q == XS_LAUNCH);
    assign bus_run_o    = !ready_o;
    assign slot_end     = qtick_i && (phase_q == 2'd3);
    assign sample_now   = qtick_i && (phase_q == 2'd2);

    // Sequence the slots, shift the bytes and latch the results.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= XS_IDLE;
            stage_q <= BY_ADDR_W;
            phase_q <= '0;
            bit_q   <= '0;
            shift_q <= '0;
            cmd_q   <= '0;
            rdata_q <= '0;
            nack_q  <= 1'b0;
        end else begin
            case (state_q)
                XS_IDLE: begin
                    if (start_i) begin
                        cmd_q   <= cmd_i;
                        nack_q  <= 1'b0;
                        state_q <= XS_LAUNCH;
                    end
                end
                XS_LAUNCH: begin
                    if (launch_done_i) begin
                        state_q <= XS_START;
                        phase_q <= '0;
                    end
                end
                default: begin
                    if (sample_now) begin
                        if (state_q == XS_TXACK && sda_i) begin
                            nack_q <= 1'b1;
                        end
                        if (state_q == XS_RXBYTE) begin
                            shift_q <= {shift_q[6:0], sda_i};
                        end
                    end
                    if (qtick_i) begin
                        phase_q <= phase_q + 1'b1;
                    end
                    if (slot_end) begin
                        case (state_q)
                            XS_START: begin
                                state_q <= XS_TXBYTE;
                                stage_q <= BY_ADDR_W;
                                shift_q <= {cmd_q.sa, 1'b0};
                                bit_q   <= '0;
                            end
                            XS_TXBYTE: begin
                                if (bit_q == 3'd7) begin
                                    state_q <= XS_TXACK;
                                end else begin
                                    bit_q   <= bit_q + 1'b1;
                                    shift_q <= {shift_q[6:0], 1'b0};
                                end
                            end
                            XS_TXACK: begin
                                bit_q <= '0;
                                if (nack_q) begin
                                    state_q <= XS_STOP;
                                end else begin
                                    case (stage_q)
                                        BY_ADDR_W: begin
                                            shift_q <= cmd_q.ra;
                                            stage_q <= BY_REG;
                                            state_q <= XS_TXBYTE;
                                        end
                                        BY_REG: begin
                                            if (cmd_q.rd) begin
                                                state_q <= XS_RSTART;
                                            end else begin
                                                shift_q <= cmd_q.wd;
                                                stage_q <= BY_DATA;
                                                state_q <= XS_TXBYTE;
                                            end
                                        end
                                        BY_DATA:   state_q <= XS_STOP;
                                        default:   state_q <= XS_RXBYTE;
                                    endcase
                                end
                            end
                            XS_RSTART: begin
                                state_q <= XS_TXBYTE;
                                stage_q <= BY_ADDR_R;
                                shift_q <= {cmd_q.sa, 1'b1};
                                bit_q   <= '0;
                            end
                            XS_RXBYTE: begin
                                if (bit_q == 3'd7) begin
                                    rdata_q <= shift_q;
                                    state_q <= XS_MNACK;
                                end else begin
                                    bit_q <= bit_q + 1'b1;
                                end
                            end
                            XS_MNACK: state_q <= XS_STOP;
                            default:  state_q <= XS_IDLE;
                        endcase
                    end
                end
            endcase
        end
    end

    // Register the line levels so the pins never glitch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lines_q <= '{scl: 1'b1, sda_pull: 1'b0};
        end else begin
            lines_q <= slot_lines(state_q, phase_q, shift_q[7]);
        end
    end

    assign nack_o   = nack_q;
    assign rdata_o  = rdata_q;
    assign cmd_sa_o = cmd_q.sa;
    assign cmd_rd_o = cmd_q.rd;
    assign cmd_ra_o = cmd_q.ra;
    assign scl_o    = lines_q.scl;
    assign sda_oe_o = lines_q.sda_pull;
endmodule

// File: rtl/i2c_reg_master.sv
`timescale 1ns/1ps
// Module: single-register I2C master, top level.
// Ties together the launch delay timer, the quarter-period timer and the
// sequencer, and packs the status word.
// Assumes open-drain lines with external pull-ups and no clock stretching.
module i2c_reg_master
    import i2c_reg_pkg::*;
#(
    parameter int unsigned QUARTER_CYC = 83,
    parameter int unsigned LAUNCH_CYC  = 132
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start_i,
    input  logic        rd_i,
    input  logic [6:0]  slave_addr_i,
    input  logic [7:0]  reg_addr_i,
    input  logic [7:0]  wdata_i,
    input  logic        sda_i,
    output logic        ready_o,
    output logic        nack_o,
    output logic [7:0]  rdata_o,
    output logic [31:0] status_o,
    output logic        scl_o,
    output logic        sda_oe_o
);
    cmd_t       cmd;
    logic       launch_run;
    logic       launch_done;
    logic       bus_run;
    logic       qtick;
    logic [6:0] cmd_sa;
    logic       cmd_rd;
    logic [7:0] cmd_ra;

    assign cmd = '{sa: slave_addr_i, rd: rd_i, ra: reg_addr_i, wd: wdata_i};

    i2c_interval_timer #(.INTERVAL(LAUNCH_CYC)) launch_tmr_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (launch_run),
        .tick_o (launch_done)
    );

    i2c_interval_timer #(.INTERVAL(QUARTER_CYC)) quarter_tmr_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (bus_run),
        .tick_o (qtick)
    );

    i2c_xfer_ctrl ctrl_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .start_i       (start_i),
        .cmd_i         (cmd),
        .launch_done_i (launch_done),
        .qtick_i       (qtick),
        .sda_i         (sda_i),
        .launch_run_o  (launch_run),
        .bus_run_o     (bus_run),
        .ready_o       (ready_o),
        .nack_o        (nack_o),
        .rdata_o       (rdata_o),
        .cmd_sa_o      (cmd_sa),
        .cmd_rd_o      (cmd_rd),
        .cmd_ra_o      (cmd_ra),
        .scl_o         (scl_o),
        .sda_oe_o      (sda_oe_o)
    );

    assign status_o = {6'd0, nack_o, ready_o, rdata_o, cmd_sa, cmd_rd, cmd_ra};
endmodule

// File: rtl/i2c_reg_master_chk.sv
`timescale 1ns/1ps
// Module: property checker for i2c_reg_master, attached by bind.
module i2c_reg_master_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       start_i,
    input logic       ready_o,
    input logic       nack_o,
    input logic [7:0] rdata_o,
    input logic       scl_o,
    input logic       sda_oe_o
);
    assert_idle_released_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ready_o |-> (scl_o && !sda_oe_o));

    assert_launch_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ready_o && start_i) |=> ready_o);

    assert_rdata_busy_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rdata_o) |-> !ready_o);

    assert_nack_rise_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nack_o) |-> !ready_o);

    assert_nack_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (nack_o && !start_i) |=> nack_o);

    assert_nack_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ready_o && start_i) |=> !nack_o);

    assert_edges_apart_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe_o) |-> $stable(scl_o));
endmodule

bind i2c_reg_master i2c_reg_master_chk chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .ready_o  (ready_o),
    .nack_o   (nack_o),
    .rdata_o  (rdata_o),
    .scl_o    (scl_o),
    .sda_oe_o (sda_oe_o)
);

// File: tb/i2c_reg_master_tb_top.sv
`timescale 1ns/1ps
module i2c_reg_master_tb_top;
    localparam int unsigned QC  = 4;
    localparam int unsigned LC  = 20;
    localparam logic [6:0]  SLV = 7'h50;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        rd_i = 1'b0;
    logic [6:0]  sa_i = '0;
    logic [7:0]  ra_i = '0;
    logic [7:0]  wd_i = '0;
    logic        sda_bus;
    logic        ready_o, nack_o, scl_o, sda_oe_o;
    logic [7:0]  rdata_o;
    logic [31:0] status_o;
    logic        slv_pull = 1'b0;

    int n_chk = 0;
    int n_fail = 0;

    // slave model state
    int         nstart = 0, nstop = 0, nbytes = 0, bad_edge = 0;
    logic [7:0] rec [0:7];
    logic [7:0] slv_rd_val = 8'h00;
    int         nack_sel = 0;
    logic       mack = 1'b0;
    int         hi_cnt = 0, lo_cnt = 0, last_hi = 0, last_lo = 0;
    logic       pscl = 1'b1, psda = 1'b1;

    assign sda_bus = !sda_oe_o && !slv_pull;

    always #10 clk = ~clk;

    i2c_reg_master #(.QUARTER_CYC(QC), .LAUNCH_CYC(LC)) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .rd_i         (rd_i),
        .slave_addr_i (sa_i),
        .reg_addr_i   (ra_i),
        .wdata_i      (wd_i),
        .sda_i        (sda_bus),
        .ready_o      (ready_o),
        .nack_o       (nack_o),
        .rdata_o      (rdata_o),
        .status_o     (status_o),
        .scl_o        (scl_o),
        .sda_oe_o     (sda_oe_o)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Behavioural slave: samples the bus at falling clock edges, changes SDA only while SCL is low.
    initial begin
        int   sst = 4;
        int   bitn = 0;
        int   didx = 0;
        logic is_addr = 1'b0;
        logic tx_next = 1'b0;
        logic ack;
        logic [7:0] shreg = '0;
        logic [7:0] txsh = '0;
        logic scl, sda;
        forever begin
            @(negedge clk);
            scl = scl_o;
            sda = sda_bus;
            if (rst_n) begin
                if (scl != pscl && sda != psda) bad_edge++;
                if (!pscl && scl) begin
                    last_lo = lo_cnt; hi_cnt = 1;
                end else if (pscl && !scl) begin
                    last_hi = hi_cnt; lo_cnt = 1;
                end else if (scl) hi_cnt++;
                else lo_cnt++;
            end
            if (pscl && scl && psda && !sda) begin
                nstart++; sst = 0; bitn = 0; didx = 0; is_addr = 1'b1; slv_pull = 1'b0;
            end else if (pscl && scl && !psda && sda) begin
                nstop++; sst = 4; slv_pull = 1'b0;
            end else if (!pscl && scl) begin
                if (sst == 0) begin
                    shreg = {shreg[6:0], sda}; bitn++;
                end else if (sst == 2) begin
                    bitn++;
                end else if (sst == 3) begin
                    mack = sda;
                end
            end else if (pscl && !scl) begin
                case (sst)
                    0: if (bitn == 8) begin
                        rec[nbytes % 8] = shreg;
                        nbytes++;
                        if (is_addr) begin
                            ack = (shreg[7:1] == SLV) && (nack_sel != 1);
                            tx_next = shreg[0];
                        end else begin
                            ack = !((nack_sel == 2 && didx == 0) || (nack_sel == 3 && didx == 1));
                            tx_next = 1'b0;
                            didx++;
                        end
                        is_addr = 1'b0;
                        slv_pull = ack;
                        sst = ack ? 1 : 4;
                        bitn = 0;
                    end
                    1: begin
                        slv_pull = 1'b0;
                        if (tx_next) begin
                            txsh = slv_rd_val; slv_pull = !txsh[7]; sst = 2; bitn = 0;
                        end else begin
                            sst = 0;
                        end
                    end
                    2: if (bitn == 8) begin
                        slv_pull = 1'b0; sst = 3;
                    end else begin
                        txsh = {txsh[6:0], 1'b0}; slv_pull = !txsh[7];
                    end
                    3: sst = 4;
                    default: ;
                endcase
            end
            pscl = scl;
            psda = sda;
        end
    end

    task automatic slv_arm(input int sel, input logic [7:0] rdv);
        nstart = 0; nstop = 0; nbytes = 0; mack = 1'b0; bad_edge = 0;
        nack_sel = sel; slv_rd_val = rdv;
    endtask

    task automatic issue(input logic rd, input logic [6:0] sa, input logic [7:0] ra, input logic [7:0] wd);
        @(negedge clk);
        rd_i = rd; sa_i = sa; ra_i = ra; wd_i = wd; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic wait_done(input string req);
        int n = 0;
        repeat (LC + 2) @(negedge clk);
        while (ready_o !== 1'b1 && n < 5000) begin
            @(negedge clk);
            n++;
        end
        chk(req, "completion before timeout", 32'(ready_o), 32'd1);
    endtask

    task automatic t_reset();
        chk("R1", "ready in reset", 32'(ready_o), 32'd1);
        chk("R1", "scl released in reset", 32'(scl_o), 32'd1);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        chk("R1", "ready after reset", 32'(ready_o), 32'd1);
        chk("R1", "nack after reset", 32'(nack_o), 32'd0);
        chk("R1", "rdata after reset", 32'(rdata_o), 32'd0);
        chk("R1", "sda released", 32'(sda_oe_o), 32'd0);
        chk("R9", "status after reset", status_o, 32'h0100_0000);
    endtask

    task automatic t_write();
        slv_arm(0, 8'h00);
        issue(1'b0, SLV, 8'h3C, 8'hA5);
        wait_done("R4");
        chk("R4", "start count", nstart, 1);
        chk("R4", "stop count", nstop, 1);
        chk("R4", "byte count", nbytes, 3);
        chk("R4", "address byte", 32'(rec[0]), 32'hA0);
        chk("R4", "register byte", 32'(rec[1]), 32'h3C);
        chk("R4", "data byte", 32'(rec[2]), 32'hA5);
        chk("R4", "nack clear", 32'(nack_o), 32'd0);
        chk("R8", "no simultaneous line change", bad_edge, 0);
        chk("R9", "status after write", status_o, 32'h0100_0000 | (32'(SLV) << 9) | 32'h3C);
        chk("R10", "scl high length", last_hi, 2 * QC);
        chk("R10", "scl low length", last_lo, 2 * QC);
    endtask

    task automatic t_read();
        slv_arm(0, 8'h96);
        issue(1'b1, SLV, 8'h11, 8'hFF);
        wait_done("R5");
        chk("R5", "start plus repeated start", nstart, 2);
        chk("R5", "stop count", nstop, 1);
        chk("R5", "byte count", nbytes, 3);
        chk("R5", "write address byte", 32'(rec[0]), 32'hA0);
        chk("R5", "register byte", 32'(rec[1]), 32'h11);
        chk("R5", "read address byte", 32'(rec[2]), 32'hA1);
        chk("R5", "read data", 32'(rdata_o), 32'h96);
        chk("R5", "master not-ack", 32'(mack), 32'd1);
        chk("R8", "no simultaneous line change", bad_edge, 0);
        chk("R9", "status after read", status_o,
            32'h0100_0000 | (32'h96 << 16) | (32'(SLV) << 9) | 32'h100 | 32'h11);
    endtask

    task automatic t_nack_launch();
        int bad = 0;
        slv_arm(1, 8'h00);
        issue(1'b0, SLV, 8'h20, 8'h01);
        wait_done("R6");
        chk("R6", "nack on address", 32'(nack_o), 32'd1);
        chk("R6", "only address sent", nbytes, 1);
        chk("R6", "stop after nack", nstop, 1);
        chk("R6", "rdata kept", 32'(rdata_o), 32'h96);
        repeat (10) @(negedge clk);
        chk("R6", "nack holds", 32'(nack_o), 32'd1);
        slv_arm(0, 8'h3B);
        issue(1'b1, SLV, 8'h05, 8'h00);
        chk("R7", "nack cleared by strobe", 32'(nack_o), 32'd0);
        if (ready_o !== 1'b1 || scl_o !== 1'b1 || sda_oe_o !== 1'b0 || rdata_o !== 8'h96) bad++;
        repeat (LC - 1) begin
            @(negedge clk);
            if (ready_o !== 1'b1 || scl_o !== 1'b1 || sda_oe_o !== 1'b0 || rdata_o !== 8'h96) bad++;
        end
        chk("R3", "cycles disturbed during launch", bad, 0);
        @(negedge clk);
        chk("R3", "ready falls after launch", 32'(ready_o), 32'd0);
        wait_done("R3");
        chk("R5", "new read data", 32'(rdata_o), 32'h3B);
    endtask

    task automatic t_nack_reg_read();
        slv_arm(2, 8'h77);
        issue(1'b1, SLV, 8'h44, 8'h00);
        wait_done("R6");
        chk("R6", "nack on register", 32'(nack_o), 32'd1);
        chk("R6", "two bytes sent", nbytes, 2);
        chk("R6", "no repeated start", nstart, 1);
        chk("R6", "stop count", nstop, 1);
        chk("R6", "rdata unchanged", 32'(rdata_o), 32'h3B);
    endtask

    task automatic t_nack_data_write();
        slv_arm(3, 8'h00);
        issue(1'b0, SLV, 8'h45, 8'hC3);
        wait_done("R6");
        chk("R6", "nack on data", 32'(nack_o), 32'd1);
        chk("R6", "three bytes sent", nbytes, 3);
        chk("R6", "stop count", nstop, 1);
    endtask

    task automatic t_busy_ignore();
        int bad = 0;
        slv_arm(0, 8'h00);
        issue(1'b0, SLV, 8'h40, 8'h5A);
        repeat (5) @(negedge clk);
        issue(1'b1, SLV, 8'h99, 8'h00);
        repeat (100) @(negedge clk);
        issue(1'b1, 7'h12, 8'h77, 8'h11);
        wait_done("R2");
        chk("R2", "byte count", nbytes, 3);
        chk("R2", "register byte", 32'(rec[1]), 32'h40);
        chk("R2", "data byte", 32'(rec[2]), 32'h5A);
        chk("R2", "single start", nstart, 1);
        chk("R2", "latched command", status_o[15:0], (16'(SLV) << 9) | 16'h40);
        repeat (200) begin
            @(negedge clk);
            if (ready_o !== 1'b1) bad++;
        end
        chk("R2", "no follow-on transaction", bad + nstart, 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL R2 watchdog expired actual=%0d expected=%0d", 150000, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_write();
        t_read();
        t_nack_launch();
        t_nack_reg_read();
        t_nack_data_write();
        t_busy_ignore();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule